// File: doc/BRIEF.md
# Regulator Control Register Slave on a Two-Wire Serial Bus

This block gives a host processor access to the control bytes of a five-output regulator controller over a standard two-wire serial bus (I2C). It sits behind a synchronizer on the clock and data lines. It answers one 7-bit address, and it holds seven 8-bit registers. Five registers hold a voltage code and an active-discharge flag for each output. One holds reset and power-good settings. One holds the on/off bits of the five outputs. All register bits are driven out in parallel to the analog side.

A host writes a register with three bytes: the address with the write bit, a register pointer, and the data. It reads a register in one of two ways. It can set the pointer and then issue a repeated start with the read bit. It can also set the pointer, release the bus with a stop, and return later with a read. The pointer never advances by itself. The data line is modelled as a pull-low enable for an open-drain pad. While the chip-enable input is low, the registers are held at their defaults and the slave stays off the bus.

Top module: `pmic_i2c_regs`

## Requirements
- R1: The slave acknowledges only the 7-bit address {6'b000100, addr_strap}, that is 0x08 or 0x09. Every other address, including the general-call address 0x00, gets no acknowledge, and the pull-low output stays off for the rest of that transfer.
- R2: In a write transfer (address with R/W=0, pointer byte, data byte), every byte is acknowledged and the addressed register takes the data byte. A register changes only through such a data byte, or through the defaults of R8 and R9.
- R3: In a combined read (address with W, pointer byte, repeated start, address with R=1), the slave returns the selected register MSB first, one bit per SCL low phase.
- R4: The pointer is kept across a stop and across transfers to other addresses. A later read-address transfer returns the register selected earlier.
- R5: The pointer never increments or decrements. Extra data bytes in one write all go to the same register. Extra read bytes after a master acknowledge repeat the same register.
- R6: A data byte written to a pointer of 0x07 or higher is acknowledged and discarded. A read from such a pointer returns 0x00.
- R7: Register n (0 to 6) appears on reg_flat[8n+7:8n]. In registers 0 to 4, bits 4:0 are the voltage code and bit 5 is active discharge. Register 6, bits 0 to 4, are the on/off bits of outputs A to E.
- R8: The default of registers 0 to 4 has bit 5 set and a voltage code of (mV−1450)/50. The voltage is 2800 mV for registers 1, 3 and 4 and 2600 mV for register 2. For register 0 it is 2800 mV when vsel_strap is high and 1800 mV when it is low. Register 5 defaults to 0x06 and register 6 to 0x07 (A, B and C on).
- R9: While chip_en is low, all registers hold their defaults, the slave acknowledges nothing, and the pointer returns to 0x00.
- R10: A start or stop condition aborts any transfer in progress. A partly received byte has no effect, and the pull-low output is released.
- R11: The slave samples SDA on the rising SCL edge and changes its pull-low output only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low holds defaults and silences the slave |
| addr_strap | input | 1 | Lowest bit of the 7-bit slave address |
| vsel_strap | input | 1 | Selects the default voltage of register 0 |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | Pull SDA low when 1; release when 0 |
| reg_flat | output | NUM_REGS*8 | All registers, register n at bits 8n+7:8n |

## Verification
The bench sweeps all 128 addresses. A decoder that ignored the strap bit, or that answered the general call, would acknowledge a second address. It writes and reads back every register under both strap values, mixing combined and stop-separated reads. A pointer cleared at stop would return register 0 instead of the register selected earlier. It sends several data bytes in one transfer and reads several bytes in one transfer. An auto-incrementing pointer would then spill into the next register. It also covers pointers outside the map, a transfer aborted by a stop in the middle of a byte, and chip enable dropped after writes. A slave that committed a partial byte, or that kept its values through disable, would leave a non-default byte on reg_flat.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_F,
    ST_ACK_H,
    ST_TX,
    ST_MACK,
    ST_RELOAD,
    ST_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_t;

  // voltage code for a target in millivolts: 50 mV steps from 1450 mV
  function automatic logic [4:0] volt_code(input int mv);
    return 5'((mv - 1450) / 50);
  endfunction

  // power-up / disabled value of register idx
  function automatic logic [7:0] reg_default(input int idx, input logic vsel);
    logic [7:0] v;
    case (idx)
      0:       v = {3'b001, volt_code(vsel ? 2800 : 1800)};
      2:       v = {3'b001, volt_code(2600)};
      1, 3, 4: v = {3'b001, volt_code(2800)};
      5:       v = 8'h06;
      6:       v = 8'h07;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic addr_match(input logic [5:0] id, input logic strap,
                                      input logic [6:0] addr);
    return addr == {id, strap};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import pmic_i2c_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       strap,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_data
);
  bus_state_t state;
  rx_phase_t  phase;
  logic [3:0] cnt;
  logic [6:0] shreg;
  logic [7:0] txsh;
  logic       rd_mode;
  logic [7:0] byte_in;

  assign byte_in = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      rd_mode  <= 1'b0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!en) begin
        state    <= ST_IDLE;
        ptr      <= '0;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (start_evt) begin
        state    <= ST_RX;
        phase    <= PH_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= byte_in[6:0];
            if (cnt == 4'd7) begin
              cnt   <= '0;
              state <= ST_ACK_F;
              case (phase)
                PH_ADDR: begin
                  if (addr_match(DEV_ID, strap, byte_in[7:1])) rd_mode <= byte_in[0];
                  else state <= ST_IGNORE;
                end
                PH_PTR: ptr <= byte_in;
                default: begin
                  wr_stb  <= 1'b1;
                  wr_data <= byte_in;
                end
              endcase
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
          ST_ACK_F: if (scl_fall) begin
            sda_pull <= 1'b1;
            state    <= ST_ACK_H;
          end
          ST_ACK_H: if (scl_fall) begin
            cnt <= '0;
            if (phase == PH_ADDR && rd_mode) begin
              txsh     <= rd_data;
              sda_pull <= ~rd_data[7];
              state    <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
              phase    <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_MACK;
              end else begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_pull <= ~txsh[6];
              end
            end
          end
          ST_MACK: if (scl_rise) state <= sda_s ? ST_IGNORE : ST_RELOAD;
          ST_RELOAD: if (scl_fall) begin
            cnt      <= '0;
            txsh     <= rd_data;
            sda_pull <= ~rd_data[7];
            state    <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmic_reg_bank.sv
module pmic_reg_bank
  import pmic_i2c_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chip_en,
  input  logic                  vsel,
  input  logic                  wr_stb,
  input  logic [7:0]            ptr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] reg_flat
);
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              q <= reg_default(g, vsel);
        else if (!chip_en)                       q <= reg_default(g, vsel);
        else if (wr_stb && ptr == 8'(g))         q <= wr_data;
      assign reg_flat[g*8 +: 8] = q;
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == 8'(i)) rd_data = reg_flat[i*8 +: 8];
  end
endmodule

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs #(
  parameter int         NUM_REGS    = 7,
  parameter logic [5:0] DEV_ID      = 6'b000100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chip_en,
  input  logic                  addr_strap,
  input  logic                  vsel_strap,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull,
  output logic [NUM_REGS*8-1:0] reg_flat
);
  logic       scl_sync, sda_sync, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_stb;
  logic [7:0] cur_ptr, wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_slave_fsm #(.DEV_ID(DEV_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .strap(addr_strap), .sda_s(sda_sync),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .sda_pull(sda_pull), .ptr(cur_ptr), .wr_stb(wr_stb),
    .wr_data(wr_data)
  );

  pmic_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .vsel(vsel_strap), .wr_stb(wr_stb),
    .ptr(cur_ptr), .wr_data(wr_data), .rd_data(rd_data), .reg_flat(reg_flat)
  );
endmodule

// File: rtl/pmic_i2c_regs_chk.sv
module pmic_i2c_regs_chk #(
  parameter int NUM_REGS = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  chip_en,
  input logic                  scl_sync,
  input logic                  sda_pull,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  wr_stb,
  input logic [7:0]            cur_ptr,
  input logic [7:0]            wr_data,
  input logic [NUM_REGS*8-1:0] reg_flat
);
  // R11
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_evt || stop_evt) && $past(chip_en))
      |-> !$past(scl_sync));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !sda_pull);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt || start_evt) |=> !sda_pull);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && wr_stb && int'(cur_ptr) < NUM_REGS)
      |=> reg_flat[int'($past(cur_ptr))*8 +: 8] == $past(wr_data));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !wr_stb) |=> $stable(reg_flat));

  // R6
  oob_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && wr_stb && int'(cur_ptr) >= NUM_REGS) |=> $stable(reg_flat));
endmodule

bind pmic_i2c_regs pmic_i2c_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .scl_sync(scl_sync),
  .sda_pull(sda_pull), .start_evt(start_evt), .stop_evt(stop_evt),
  .wr_stb(wr_stb), .cur_ptr(cur_ptr), .wr_data(wr_data), .reg_flat(reg_flat)
);

// File: tb/pmic_i2c_regs_bench.sv
`timescale 1ns/1ps
module pmic_i2c_regs_bench;
  localparam int Q = 8;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0, chip_en = 1'b1, a0 = 1'b0, vsel = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] reg_flat;
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  int pull_bad = 0, pull_changes = 0;
  logic prev_pull = 1'b0;
  logic [7:0] model [NR];
  bit done = 0;

  assign sda_bus = m_sda & ~sda_pull;
  always #10 clk = ~clk;

  pmic_i2c_regs u_pmic_i2c_regs (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_strap(a0), .vsel_strap(vsel),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_pull(sda_pull), .reg_flat(reg_flat)
  );

  function automatic logic [7:0] bdef(input int i, input logic v);
    int mv;
    case (i)
      0: mv = v ? 2800 : 1800;
      2: mv = 2600;
      default: mv = 2800;
    endcase
    if (i < 5) return 8'h20 | 8'((mv - 1450) / 50);
    if (i == 5) return 8'h06;
    return 8'h07;
  endfunction

  function automatic logic [7:0] rbyte(input int i);
    return reg_flat[i*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); m_sda = 1'b0; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(); m_scl = 1'b1; tick(); m_sda = 1'b1; tick();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(); m_scl = 1'b1; tick(); s = sda_bus; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  function automatic logic [7:0] adr(input logic rw);
    return {6'b000100, a0, rw};
  endfunction

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); send_byte(adr(1'b0), k1); send_byte(p, k2); send_byte(d, k3); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic rd_comb(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); send_byte(adr(1'b0), k1); send_byte(p, k2);
    bus_start(); send_byte(adr(1'b1), k3); recv_byte(1'b0, d); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic rd_sep(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); send_byte(adr(1'b0), k1); send_byte(p, k2); bus_stop();
    bus_start(); send_byte(adr(1'b1), k3); recv_byte(1'b0, d); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  // R11 monitor: pull-low output may only move while SCL is low
  always begin
    @(posedge clk); #5;
    if (rst_n && chip_en) begin
      if (sda_pull !== prev_pull) begin
        pull_changes++;
        if (m_scl) pull_bad++;
      end
    end
    prev_pull = sda_pull;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ok, k1, k2, k3, k4;
    logic [7:0] d, d2, d3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 R7: reset values
    for (int i = 0; i < NR; i++) begin
      model[i] = bdef(i, 1'b1);
      chk($sformatf("R8 reset reg%0d", i), rbyte(i), model[i]);
    end
    chk("R11 idle pull", {7'd0, sda_pull}, 8'h00);

    // R8 R9: strap-dependent default of register 0
    for (int v = 0; v < 2; v++) begin
      vsel = v[0]; chip_en = 1'b0; repeat (4) @(negedge clk);
      chip_en = 1'b1; repeat (4) @(negedge clk);
      chk($sformatf("R8 reg0 vsel=%0d", v), rbyte(0), bdef(0, v[0]));
    end
    vsel = 1'b1; chip_en = 1'b0; repeat (4) @(negedge clk); chip_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R7: sweep every register under both straps
    for (int a = 0; a < 2; a++) begin
      a0 = a[0];
      for (int p = 0; p < NR; p++) begin
        d = 8'((p * 53 + a * 29 + 11) & 255);
        wr_reg(8'(p), d, ok);
        chk($sformatf("R2 ack reg%0d", p), {7'd0, ok}, 8'h01);
        model[p] = d;
        chk($sformatf("R7 reg%0d out", p), rbyte(p), d);
        if (p % 2 == 0) begin
          rd_comb(8'(p), d2, ok);
          chk($sformatf("R3 comb reg%0d", p), d2, d);
        end else begin
          rd_sep(8'(p), d2, ok);
          chk($sformatf("R4 sep reg%0d", p), d2, d);
        end
        chk($sformatf("R3 rd ack reg%0d", p), {7'd0, ok}, 8'h01);
      end
    end

    // R1: address sweep with a0 = 1
    a0 = 1'b1;
    for (int x = 0; x < 128; x++) begin
      bus_start(); send_byte({7'(x), 1'b0}, k1); bus_stop();
      chk($sformatf("R1 addr 0x%02h", x), {7'd0, k1}, (x == 9) ? 8'h01 : 8'h00);
    end
    for (int i = 0; i < NR; i++) chk($sformatf("R1 regs kept reg%0d", i), rbyte(i), model[i]);

    // R6: pointers beyond the map
    wr_reg(8'h07, 8'hAA, ok);  chk("R6 ack ptr7", {7'd0, ok}, 8'h01);
    wr_reg(8'hFF, 8'h55, ok);  chk("R6 ack ptrFF", {7'd0, ok}, 8'h01);
    for (int i = 0; i < NR; i++) chk($sformatf("R6 regs kept reg%0d", i), rbyte(i), model[i]);
    rd_comb(8'h07, d, ok);  chk("R6 read ptr7", d, 8'h00);
    rd_sep(8'h80, d, ok);   chk("R6 read ptr80", d, 8'h00);

    // R5: no auto-increment on write
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h01, k2);
    send_byte(8'h3C, k3); send_byte(8'hC3, k4); bus_stop();
    chk("R5 multi-write ack", {7'd0, k1 & k2 & k3 & k4}, 8'h01);
    model[1] = 8'hC3;
    chk("R5 reg1 last byte", rbyte(1), 8'hC3);
    chk("R5 reg2 untouched", rbyte(2), model[2]);
    // R5: no auto-increment on read
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h04, k2);
    bus_start(); send_byte(adr(1'b1), k3);
    recv_byte(1'b1, d); recv_byte(1'b1, d2); recv_byte(1'b0, d3); bus_stop();
    chk("R5 read b0", d, model[4]);
    chk("R5 read b1", d2, model[4]);
    chk("R5 read b2", d3, model[4]);

    // R4: pointer survives stop and a foreign transfer
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h03, k2); bus_stop();
    bus_start(); send_byte(8'h44, k3); bus_stop();
    chk("R4 foreign nack", {7'd0, k3}, 8'h00);
    bus_start(); send_byte(adr(1'b1), k1); recv_byte(1'b0, d); bus_stop();
    chk("R4 kept pointer", d, model[3]);

    // R10: stop in the middle of a data byte
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h02, k2);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, k3);
    bus_stop();
    chk("R10 stop abort", rbyte(2), model[2]);
    // R10: repeated start in the middle of a data byte
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h02, k2);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, k3);
    bus_start(); send_byte(adr(1'b0), k1); send_byte(8'h02, k2); send_byte(8'h3C, k3); bus_stop();
    model[2] = 8'h3C;
    chk("R10 restart write", rbyte(2), 8'h3C);
    chk("R10 restart ack", {7'd0, k1 & k2 & k3}, 8'h01);

    // R9: chip enable low
    chip_en = 1'b0; repeat (4) @(negedge clk);
    for (int i = 0; i < NR; i++) chk($sformatf("R9 default reg%0d", i), rbyte(i), bdef(i, vsel));
    bus_start(); send_byte(adr(1'b0), k1); bus_stop();
    chk("R9 no ack disabled", {7'd0, k1}, 8'h00);
    chip_en = 1'b1; repeat (4) @(negedge clk);
    bus_start(); send_byte(adr(1'b1), k1); recv_byte(1'b0, d); bus_stop();
    chk("R9 pointer cleared", d, bdef(0, vsel));

    // R11: timing of the pull-low output over the whole run
    chk("R11 pull moved with SCL high", 8'(pull_bad), 8'h00);
    chk("R11 pull activity seen", {7'd0, pull_changes > 0}, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule